// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block turns a stream of captured bus-write cycles (an address plus a data word) into flash commands. It accepts these commands: Read/Reset, Auto Select, Program, Unlock Bypass with its short program and exit forms, Chip Erase, multi-block Block Erase, Erase Suspend and Erase Resume. It reports the current operating mode, issues one-cycle program and erase requests, and drives a ready flag. A small built-in engine stub holds the block busy for a settable number of cycles after each request.

The write address is a byte address `{A17..A0, A-1}`. In word mode bit 0 carries no address meaning. The bus width selection moves the unlock addresses: the word-mode unlock pair 555h/2AAh becomes AAAh/555h in byte mode. After a Block Erase is accepted, the block stays in a collection window. Each further 30h write adds one block to the erase mask and restarts the window. When the window runs out, the erase request is issued with the accumulated mask.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Only address bits [11:0] in byte mode (bits [11:1] in word mode) and data bits [7:0] take part in command matching. Higher address bits and data bits [15:8] have no effect.
- R2: The first unlock cycle is AAh to address 555h (word) or AAAh (byte). The second is 55h to 2AAh (word) or 555h (byte). Command writes that need an unlock address use the first unlock address.
- R3: Unlock, unlock, then 90h enters auto select (`mode`=1). The block stays there through unrelated writes. A single F0h write returns it to read-array (`mode`=0).
- R4: Unlock, unlock, A0h, then a fourth write pulses `prog_req` for one cycle, with `prog_addr`/`prog_data` equal to that write. `ready` is then low for exactly max(`busy_len`,1) cycles, and `mode`=3 while busy.
- R5: Chip Erase is unlock, unlock, 80h, unlock, unlock, then 10h to the unlock address. It pulses `erase_req` with `erase_chip`=1 and `erase_mask`=7FFh.
- R6: Block Erase ends in 30h to any address of the target block. Each further 30h write within `erase_window` idle cycles ORs in another block. The window then closes and `erase_req` pulses with `erase_chip`=0 and the mask. Block index: byte address 7C000h and up is 10, 7A000h is 9, 78000h is 8, 70000h is 7, and otherwise address bits [18:16]. Mask bit n stands for block n.
- R7: Unlock, unlock, 20h enters bypass (`mode`=2). There, A0h plus one program write issues a program and then returns to bypass. 90h then 00h returns to read-array.
- R8: Read/Reset works either as one F0h write or as unlock, unlock, F0h.
- R9: A write that breaks a sequence returns the block to read-array mode.
- R10: During a block erase, B0h suspends it: `mode`=4 and `ready`=1. While suspended, a program into a block in the erase mask is refused, a program elsewhere runs and then returns to suspended, and 30h resumes the erase, which then completes to read-array.
- R11: `ready` is low while an operation runs or while the erase window is open, and high in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 = 8-bit bus addressing, 0 = 16-bit |
| wr_valid | input | 1 | One captured bus write this cycle |
| wr_addr | input | 19 | Write byte address {A17..A0,A-1} |
| wr_data | input | 16 | Write data |
| busy_len | input | CNT_W | Engine busy duration in cycles |
| erase_window | input | CNT_W | Idle cycles the block-collection window stays open |
| mode | output | 3 | 0 read, 1 auto select, 2 bypass, 3 busy, 4 erase suspended |
| ready | output | 1 | 1 = ready, 0 = busy |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | 19 | Program address |
| prog_data | output | 16 | Program data |
| erase_req | output | 1 | One-cycle erase request |
| erase_chip | output | 1 | Erase request covers the whole chip |
| erase_mask | output | 11 | Blocks to erase |

## Verification
The assertions assume that `busy_len` and `erase_window` stay unchanged while an operation or window is in progress. They also assume `byte_mode` changes only while the block is idle. The stimulus sets these inputs only between commands, after `ready` has returned high. Random stimulus fills the ignored address and data bits with noise and switches between byte and word modes between commands.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int ADDR_W  = 19;
  localparam int DATA_W  = 16;
  localparam int NUM_BLK = 11;
  localparam int BLK_W   = 4;

  localparam logic [2:0] MODE_READ = 3'd0;
  localparam logic [2:0] MODE_ASEL = 3'd1;
  localparam logic [2:0] MODE_BYP  = 3'd2;
  localparam logic [2:0] MODE_BUSY = 3'd3;
  localparam logic [2:0] MODE_SUSP = 3'd4;

  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_PARM, S_E3, S_E4, S_E5, S_WIN,
    S_BUSY, S_SUSP, S_ASEL, S_BYP, S_BPROG, S_BRST
  } fcd_state_t;

  // first unlock address (also the command address)
  function automatic logic hit_first(input logic bm, input logic [11:0] a);
    return bm ? (a == 12'hAAA) : (a[11:1] == 11'h555);
  endfunction

  function automatic logic hit_second(input logic bm, input logic [11:0] a);
    return bm ? (a == 12'h555) : (a[11:1] == 11'h2AA);
  endfunction

  // block index from word address bits [17:12]
  function automatic logic [BLK_W-1:0] blk_of(input logic [5:0] w);
    if (w[5:3] != 3'b111) return {1'b0, w[5:3]};
    else if (!w[2])       return 4'd7;
    else if (w[1])        return 4'd10;
    else if (w[0])        return 4'd9;
    else                  return 4'd8;
  endfunction
endpackage

// File: rtl/fcd_engine.sv
module fcd_engine #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  input  logic             suspend,
  input  logic             resume,
  output logic             running,
  output logic             done
);
  logic [CNT_W-1:0] cnt, saved;

  assign done = running && (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; saved <= '0; running <= 1'b0;
    end else if (start) begin
      cnt     <= (len == '0) ? CNT_W'(1) : len;
      running <= 1'b1;
    end else if (suspend) begin
      saved   <= cnt - CNT_W'(1);
      running <= 1'b0;
    end else if (resume) begin
      cnt     <= saved;
      running <= 1'b1;
    end else if (running) begin
      if (done) running <= 1'b0;
      else      cnt <= cnt - CNT_W'(1);
    end
  end

  p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !running);
  p_start_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> running);
  p_resume_left_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (saved != '0) && !running);
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_mode,
  input  logic               wr_valid,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [CNT_W-1:0]   erase_window,
  input  logic               eng_done,
  output logic               start_op,
  output logic               suspend_ev,
  output logic               resume_ev,
  output logic [2:0]         mode,
  output logic               ready,
  output logic               prog_req,
  output logic [ADDR_W-1:0]  prog_addr,
  output logic [DATA_W-1:0]  prog_data,
  output logic               erase_req,
  output logic               erase_chip,
  output logic [NUM_BLK-1:0] erase_mask
);
  fcd_state_t st, st_n, ret, ret_n, home;
  logic [NUM_BLK-1:0] mask_n;
  logic [CNT_W-1:0]   win, win_n;
  logic susp, susp_n, eblk, eblk_n, chip_n;
  logic start_prog, start_erase;

  logic [7:0]         d;
  logic               ua, ub;
  logic [BLK_W-1:0]   blk;
  logic [NUM_BLK-1:0] blk_bit;

  assign d       = wr_data[7:0];
  assign ua      = hit_first(byte_mode, wr_addr[11:0]);
  assign ub      = hit_second(byte_mode, wr_addr[11:0]);
  assign blk     = blk_of(wr_addr[ADDR_W-1:13]);
  assign blk_bit = NUM_BLK'(1) << blk;
  assign home    = susp ? S_SUSP : S_READ;

  always_comb begin
    st_n = st; ret_n = ret; mask_n = erase_mask; win_n = win;
    susp_n = susp; eblk_n = eblk; chip_n = erase_chip;
    start_prog = 1'b0; start_erase = 1'b0;
    suspend_ev = 1'b0; resume_ev = 1'b0;
    case (st)
      S_READ, S_ASEL, S_SUSP: if (wr_valid) begin
        if (d == 8'hF0) st_n = home;
        else if (ua && d == 8'hAA) st_n = S_U1;
        else if (st == S_SUSP && d == 8'h30) begin
          resume_ev = 1'b1; susp_n = 1'b0; eblk_n = 1'b1;
          ret_n = S_READ; st_n = S_BUSY;
        end
      end
      S_U1: if (wr_valid) st_n = (ub && d == 8'h55) ? S_U2 : home;
      S_U2: if (wr_valid) begin
        st_n = home;
        if (ua) begin
          case (d)
            8'h90: st_n = S_ASEL;
            8'hA0: st_n = S_PARM;
            8'h20: if (!susp) st_n = S_BYP;
            8'h80: if (!susp) st_n = S_E3;
            default: st_n = home;
          endcase
        end
      end
      S_PARM: if (wr_valid) begin
        if (susp && erase_mask[blk]) st_n = home;
        else begin
          start_prog = 1'b1; ret_n = home; eblk_n = 1'b0; st_n = S_BUSY;
        end
      end
      S_E3: if (wr_valid) st_n = (ua && d == 8'hAA) ? S_E4 : S_READ;
      S_E4: if (wr_valid) st_n = (ub && d == 8'h55) ? S_E5 : S_READ;
      S_E5: if (wr_valid) begin
        st_n = S_READ;
        if (ua && d == 8'h10) begin
          start_erase = 1'b1; chip_n = 1'b1; mask_n = '1;
          eblk_n = 1'b0; ret_n = S_READ; st_n = S_BUSY;
        end else if (d == 8'h30) begin
          chip_n = 1'b0; mask_n = blk_bit; win_n = erase_window; st_n = S_WIN;
        end
      end
      S_WIN: begin
        if (wr_valid) begin
          if (d == 8'h30) begin
            mask_n = erase_mask | blk_bit; win_n = erase_window;
          end else st_n = S_READ;
        end else if (win <= CNT_W'(1)) begin
          start_erase = 1'b1; eblk_n = 1'b1; ret_n = S_READ; st_n = S_BUSY;
        end else win_n = win - CNT_W'(1);
      end
      S_BUSY: begin
        if (eng_done) begin
          st_n = ret; eblk_n = 1'b0;
        end else if (wr_valid && eblk && d == 8'hB0) begin
          suspend_ev = 1'b1; susp_n = 1'b1; st_n = S_SUSP;
        end
      end
      S_BYP: if (wr_valid) begin
        if (d == 8'hA0)      st_n = S_BPROG;
        else if (d == 8'h90) st_n = S_BRST;
        else                 st_n = S_READ;
      end
      S_BPROG: if (wr_valid) begin
        start_prog = 1'b1; ret_n = S_BYP; eblk_n = 1'b0; st_n = S_BUSY;
      end
      S_BRST: if (wr_valid) st_n = S_READ;
      default: st_n = S_READ;
    endcase
  end

  assign start_op = start_prog | start_erase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_READ; ret <= S_READ; erase_mask <= '0; win <= '0;
      susp <= 1'b0; eblk <= 1'b0; erase_chip <= 1'b0;
      prog_req <= 1'b0; erase_req <= 1'b0; prog_addr <= '0; prog_data <= '0;
    end else begin
      st <= st_n; ret <= ret_n; erase_mask <= mask_n; win <= win_n;
      susp <= susp_n; eblk <= eblk_n; erase_chip <= chip_n;
      prog_req  <= start_prog;
      erase_req <= start_erase;
      if (start_prog) begin
        prog_addr <= wr_addr; prog_data <= wr_data;
      end
    end
  end

  always_comb begin
    case (st)
      S_ASEL:                 mode = MODE_ASEL;
      S_BYP, S_BPROG, S_BRST: mode = MODE_BYP;
      S_BUSY, S_WIN:          mode = MODE_BUSY;
      default:                mode = susp ? MODE_SUSP : MODE_READ;
    endcase
  end
  assign ready = !(st == S_BUSY || st == S_WIN);

  p_req_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, erase_req}));
  p_req_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req || erase_req) |-> !ready && mode == MODE_BUSY);
  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> erase_mask != '0);
  p_suspend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_ev |=> mode == MODE_SUSP && ready);
  p_chip_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && erase_chip) |-> &erase_mask);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_mode,
  input  logic             wr_valid,
  input  logic [18:0]      wr_addr,
  input  logic [15:0]      wr_data,
  input  logic [CNT_W-1:0] busy_len,
  input  logic [CNT_W-1:0] erase_window,
  output logic [2:0]       mode,
  output logic             ready,
  output logic             prog_req,
  output logic [18:0]      prog_addr,
  output logic [15:0]      prog_data,
  output logic             erase_req,
  output logic             erase_chip,
  output logic [10:0]      erase_mask
);
  logic start_op, suspend_ev, resume_ev, eng_running, eng_done;

  fcd_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .erase_window(erase_window),
    .eng_done(eng_done), .start_op(start_op), .suspend_ev(suspend_ev),
    .resume_ev(resume_ev), .mode(mode), .ready(ready), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .erase_req(erase_req),
    .erase_chip(erase_chip), .erase_mask(erase_mask)
  );

  fcd_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_op), .len(busy_len),
    .suspend(suspend_ev), .resume(resume_ev), .running(eng_running),
    .done(eng_done)
  );

  p_run_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_running |-> !ready);
endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, byte_mode = 1'b0, wr_valid = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [15:0] wr_data = '0, busy_len = 16'd3, erase_window = 16'd8;
  logic [2:0]  mode;
  logic ready, prog_req, erase_req, erase_chip;
  logic [18:0] prog_addr;
  logic [15:0] prog_data;
  logic [10:0] erase_mask;
  int nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy_len(busy_len),
    .erase_window(erase_window), .mode(mode), .ready(ready),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_req(erase_req), .erase_chip(erase_chip), .erase_mask(erase_mask)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // unlock addresses with noise in the ignored upper bits
  function automatic logic [18:0] addr_a(input logic bm, input logic [18:0] n);
    return bm ? {n[18:12], 12'hAAA} : {n[18:12], 11'h555, n[0]};
  endfunction
  function automatic logic [18:0] addr_b(input logic bm, input logic [18:0] n);
    return bm ? {n[18:12], 12'h555} : {n[18:12], 11'h2AA, n[0]};
  endfunction
  function automatic int exp_blk(input logic [18:0] a);
    if (a >= 19'h7C000) return 10;
    if (a >= 19'h7A000) return 9;
    if (a >= 19'h78000) return 8;
    if (a >= 19'h70000) return 7;
    return int'(a[18:16]);
  endfunction
  function automatic logic [15:0] cmd(input logic [7:0] c);
    return {8'($urandom), c};
  endfunction

  task automatic wr(input logic [18:0] a, input logic [15:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask
  task automatic unlock2;
    wr(addr_a(byte_mode, 19'($urandom)), cmd(8'hAA));
    wr(addr_b(byte_mode, 19'($urandom)), cmd(8'h55));
  endtask
  task automatic cmd3(input logic [7:0] c);
    unlock2();
    wr(addr_a(byte_mode, 19'($urandom)), cmd(c));
  endtask
  task automatic busy_cycles(output int n);
    n = 0;
    while (!ready && n < 5000) begin n++; @(negedge clk); end
  endtask
  task automatic wait_erase(output int n);
    n = 0;
    while (!erase_req && n < 500) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    logic [18:0] pa;
    logic [15:0] pd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode == 3'd0 && ready && !prog_req && !erase_req, "R11 reset", mode, 0);

    // R3 auto select in word mode, persistence, F0 exit
    cmd3(8'h90);
    chk(mode == 3'd1, "R3 enter", mode, 1);
    wr(19'h01234, cmd(8'h12));
    chk(mode == 3'd1, "R3 persists", mode, 1);
    wr(19'h00000, cmd(8'hF0));
    chk(mode == 3'd0, "R3/R8 single F0", mode, 0);

    // R8 three-write reset from auto select, byte mode
    byte_mode = 1'b1;
    cmd3(8'h90);
    chk(mode == 3'd1, "R3 byte enter", mode, 1);
    cmd3(8'hF0);
    chk(mode == 3'd0 && ready, "R8 three write reset", mode, 0);

    // R2 word address used in byte mode does not unlock
    wr({7'h0, 12'h554}, cmd(8'hAA));
    wr({7'h0, 12'h2AA}, cmd(8'h55));
    wr({7'h0, 12'h554}, cmd(8'h90));
    chk(mode == 3'd0, "R2 wrong-mode address", mode, 0);

    // R9 broken sequence
    wr(addr_a(1'b1, 19'h0), cmd(8'hAA));
    wr(addr_b(1'b1, 19'h0), cmd(8'h77));
    wr(addr_a(1'b1, 19'h0), cmd(8'h90));
    chk(mode == 3'd0, "R9 break", mode, 0);

    // R4/R1/R2 random programs in both bus modes
    for (int i = 0; i < 16; i++) begin
      byte_mode = 1'($urandom);
      busy_len = 16'(1 + $urandom % 7);
      pa = 19'($urandom); pd = 16'($urandom);
      cmd3(8'hA0);
      wr(pa, pd);
      chk(prog_req && prog_addr == pa && prog_data == pd, "R4 prog req", prog_addr, pa);
      chk(mode == 3'd3, "R4 busy mode", mode, 3);
      busy_cycles(n);
      chk(n == int'(busy_len), "R4/R11 busy length", n, busy_len);
      chk(mode == 3'd0 && !prog_req, "R1 back to read", mode, 0);
    end

    // R4 zero length treated as one
    byte_mode = 1'b0; busy_len = 16'd0;
    cmd3(8'hA0); wr(19'h00010, 16'hBEEF);
    busy_cycles(n);
    chk(n == 1, "R4 zero length", n, 1);

    // R7 bypass
    busy_len = 16'd4;
    cmd3(8'h20);
    chk(mode == 3'd2, "R7 enter bypass", mode, 2);
    wr(19'h3A3A3, cmd(8'hA0));
    wr(19'h12344, 16'hCAFE);
    chk(prog_req && prog_addr == 19'h12344 && prog_data == 16'hCAFE, "R7 short program", prog_data, 16'hCAFE);
    busy_cycles(n);
    chk(mode == 3'd2, "R7 return to bypass", mode, 2);
    wr(19'h0, cmd(8'h90)); wr(19'h0, 16'h0000);
    chk(mode == 3'd0, "R7 exit bypass", mode, 0);

    // R5 chip erase (byte mode)
    byte_mode = 1'b1; busy_len = 16'd5;
    cmd3(8'h80); cmd3(8'h10);
    chk(erase_req && erase_chip && erase_mask == 11'h7FF, "R5 chip erase", erase_mask, 11'h7FF);
    busy_cycles(n);
    chk(n == 5 && mode == 3'd0, "R5 busy then read", n, 5);

    // R6 multi-block erase
    byte_mode = 1'b0; erase_window = 16'd6; busy_len = 16'd3;
    cmd3(8'h80); unlock2();
    wr(19'h00100, cmd(8'h30));
    chk(mode == 3'd3 && !ready, "R11 window busy", mode, 3);
    wr(19'h7E010, cmd(8'h30));
    wr(19'h78800, cmd(8'h30));
    wait_erase(n);
    chk(erase_req && !erase_chip, "R6 erase issued", erase_req, 1);
    chk(erase_mask == 11'((1 << exp_blk(19'h0)) | (1 << exp_blk(19'h7E010)) | (1 << exp_blk(19'h78800))),
        "R6 mask", erase_mask, 11'h501);
    busy_cycles(n);

    // R10 suspend / resume
    busy_len = 16'd60; erase_window = 16'd2;
    cmd3(8'h80); unlock2();
    wr(19'h20000, cmd(8'h30));
    wait_erase(n);
    chk(erase_mask == 11'(1 << exp_blk(19'h20000)), "R6 single mask", erase_mask, 4);
    wr(19'h0, cmd(8'hB0));
    chk(mode == 3'd4 && ready, "R10 suspended", mode, 4);
    busy_len = 16'd2;
    cmd3(8'hA0); wr(19'h21000, 16'h1111);
    chk(!prog_req && mode == 3'd4, "R10 erasing block refused", prog_req, 0);
    cmd3(8'hA0); wr(19'h50000, 16'h2222);
    chk(prog_req && prog_addr == 19'h50000, "R10 other block program", prog_addr, 19'h50000);
    busy_cycles(n);
    chk(mode == 3'd4, "R10 back to suspended", mode, 4);
    wr(19'h0, cmd(8'h30));
    chk(mode == 3'd3 && !ready, "R10 resumed", mode, 3);
    busy_cycles(n);
    chk(mode == 3'd0 && ready && n < 60, "R10 finish to read", n, 59);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule